// File: doc/BRIEF.md
# Stopwatch tick interrupt unit

This unit turns a 100 Hz timebase enable into three interrupt sources. A chain of three mod-10 BCD digits counts the timebase pulses: hundredths, tenths and seconds. Each of the two lower digits drives a square wave with 50% duty. The wave is high while the digit is 0 to 4 and low while it is 5 to 9, so the hundredths digit gives a 10 Hz wave and the tenths digit gives a 1 Hz wave. The 100 Hz wave is the registered timebase pulse itself.

A falling edge on any of the three waves sets a sticky flag for that rate. Software sees the flags and a per-rate enable register through a byte-wide port with plain read and write strobes. A single interrupt line is raised while any flag is set and its enable bit is also set. The BCD digits can be read back. Software treats a counter value as valid only when two back-to-back reads return the same value.

Top module: `stopwatch_tick_irq`

## Requirements
- R1: After reset the enable bits, the flag bits and all three counter digits are 0, and `irq_o` is low.
- R2: Address 0 holds the enable register. Bit 0 enables the 100 Hz source, bit 1 the 10 Hz source and bit 2 the 1 Hz source. The register is writable and readable, and bits 7:3 always read as 0.
- R3: Address 1 holds the flag register, with the same bit mapping as the enable register. Bits 7:3 always read as 0.
- R4: The hundredths digit advances by one on each cycle in which `tick_i` is high and wraps from 9 to 0. The tenths digit advances when the hundredths digit wraps, and the seconds digit advances when the tenths digit wraps. Address 2 reads {tenths, hundredths} as two BCD nibbles with tenths in the upper nibble. Address 3 reads {4'h0, seconds}.
- R5: Every single-cycle `tick_i` pulse sets flag bit 0 (100 Hz) two clock edges after the edge that samples the pulse.
- R6: Flag bit 1 (10 Hz) is set once per 10 ticks, on the tick that moves the hundredths digit from 4 to 5.
- R7: Flag bit 2 (1 Hz) is set once per 100 ticks, on the tick that moves the tenths digit from 4 to 5.
- R8: Writing 1 to a flag bit clears that bit. Writing 0 to a flag bit leaves it unchanged.
- R9: When a flag's set event and a write-1 clear of that flag fall on the same clock edge, the flag ends up set.
- R10: Flags are set by their events whatever the value of the enable bits.
- R11: `irq_o` is high exactly when, for at least one rate, both the flag bit and the enable bit are 1. It stays high until those flags are cleared or their enable bits are cleared.
- R12: Writes to addresses 2 and 3 have no effect on the counter.
- R13: Read data appears on `rdata_o` on the clock edge that samples `rd_i`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz timebase enable, one cycle per period |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach is a clear write that lands on the same edge as a set event. The bench first steps the counter to a hundredths value of 4 and clears all flags. It then drives a tick and, on the very next cycle, a write-1 clear of the 10 Hz flag, so that the 4-to-5 fall and the clear coincide. The 1 Hz event happens only once per 100 ticks, so the bench sweeps 250 consecutive ticks. After every tick it compares all three flags against the arithmetic of the tick count, and it tries all eight enable patterns against the interrupt line.

// File: rtl/swt_pkg.sv
package swt_pkg;
  localparam int unsigned ADDR_EN     = 0;
  localparam int unsigned ADDR_FLAG   = 1;
  localparam int unsigned ADDR_CNT_LO = 2;
  localparam int unsigned ADDR_CNT_HI = 3;

  localparam int unsigned RATE_FAST = 0;  // 100 Hz
  localparam int unsigned RATE_MID  = 1;  // 10 Hz
  localparam int unsigned RATE_SLOW = 2;  // 1 Hz
  localparam int unsigned NUM_RATES = 3;

  localparam int unsigned BCD_MAX  = 9;
  localparam int unsigned BCD_HALF = 5;
endpackage

// File: rtl/swt_bcd_digit.sv
module swt_bcd_digit #(
  parameter int unsigned DIG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [DIG_W-1:0] digit_o,
  output logic             carry_o,
  output logic             wave_o
);
  localparam logic [DIG_W-1:0] MAX_V  = DIG_W'(swt_pkg::BCD_MAX);
  localparam logic [DIG_W-1:0] HALF_V = DIG_W'(swt_pkg::BCD_HALF);

  logic [DIG_W-1:0] digit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     digit_q <= '0;
    else if (step_i) digit_q <= (digit_q == MAX_V) ? '0 : digit_q + 1'b1;
  end

  assign digit_o = digit_q;
  assign carry_o = step_i && (digit_q == MAX_V);
  assign wave_o  = digit_q < HALF_V;
endmodule

// File: rtl/swt_fall_flag.sv
module swt_fall_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic clr_i,
  output logic set_o,
  output logic flag_o
);
  logic level_q;
  logic flag_q;

  assign set_o = level_q && !level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      level_q <= level_i;
      // set has priority over a same-cycle clear
      flag_q  <= set_o | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/swt_reg_if.sv
module swt_reg_if #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned NUM_RATES = 3,
  parameter int unsigned CNT_W     = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_RATES-1:0] flag_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic [NUM_RATES-1:0] en_o,
  output logic [NUM_RATES-1:0] clr_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam int unsigned PAD_W = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(swt_pkg::ADDR_EN);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(swt_pkg::ADDR_FLAG);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(swt_pkg::ADDR_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(swt_pkg::ADDR_CNT_HI);

  logic [NUM_RATES-1:0] en_q;
  logic [DATA_W-1:0]    rdata_q;
  logic [PAD_W-1:0]     cnt_pad;
  logic [DATA_W-1:0]    rd_mux;
  logic                 unused_wdata;

  assign cnt_pad      = PAD_W'(cnt_i);
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_RATES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        en_q <= '0;
    else if (wr_i && (addr_i == A_EN))  en_q <= wdata_i[NUM_RATES-1:0];
  end

  assign clr_o = (wr_i && (addr_i == A_FLAG)) ? wdata_i[NUM_RATES-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_EN:    rd_mux = DATA_W'(en_q);
      A_FLAG:  rd_mux = DATA_W'(flag_i);
      A_CLO:   rd_mux = cnt_pad[DATA_W-1:0];
      A_CHI:   rd_mux = cnt_pad[PAD_W-1:DATA_W];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/stopwatch_tick_irq.sv
module stopwatch_tick_irq #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DIG_W   = 4,
  parameter int unsigned NUM_DIG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned NUM_RATES = swt_pkg::NUM_RATES;
  localparam int unsigned CNT_W     = NUM_DIG * DIG_W;

  logic [NUM_DIG:0]               step_w;
  logic [NUM_DIG-1:0]             wave_w;
  logic [NUM_DIG-1:0][DIG_W-1:0]  digit_w;
  logic [NUM_RATES-1:0]           level_w;
  logic [NUM_RATES-1:0]           set_w;
  logic [NUM_RATES-1:0]           clr_w;
  logic [NUM_RATES-1:0]           flag_q;
  logic [NUM_RATES-1:0]           en_q;
  logic                           tick_q;
  logic                           unused_top;

  assign step_w[0] = tick_i;

  for (genvar d = 0; d < NUM_DIG; d++) begin : g_dig
    swt_bcd_digit #(.DIG_W(DIG_W)) u_dig (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step_w[d]),
      .digit_o (digit_w[d]),
      .carry_o (step_w[d+1]),
      .wave_o  (wave_w[d])
    );
  end

  // the 100 Hz wave is the registered timebase pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_i;
  end

  assign level_w[swt_pkg::RATE_FAST] = tick_q;
  assign level_w[swt_pkg::RATE_MID]  = wave_w[0];
  assign level_w[swt_pkg::RATE_SLOW] = wave_w[1];

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
    swt_fall_flag u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (level_w[r]),
      .clr_i   (clr_w[r]),
      .set_o   (set_w[r]),
      .flag_o  (flag_q[r])
    );
  end

  swt_reg_if #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_RATES (NUM_RATES),
    .CNT_W     (CNT_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flag_i  (flag_q),
    .cnt_i   (digit_w),
    .en_o    (en_q),
    .clr_o   (clr_w),
    .rdata_o (rdata_o)
  );

  assign irq_o      = |(flag_q & en_q);
  assign unused_top = step_w[NUM_DIG] ^ (^wave_w[NUM_DIG-1:2]);
endmodule

// File: rtl/swt_tick_irq_chk.sv
module swt_tick_irq_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned NUM_RATES = 3,
  parameter int unsigned CNT_W     = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic                 irq_o,
  input logic [NUM_RATES-1:0] set_w,
  input logic [NUM_RATES-1:0] clr_w,
  input logic [NUM_RATES-1:0] flag_q,
  input logic [CNT_W-1:0]     cnt_w
);
  p_flag_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(swt_pkg::ADDR_FLAG)) |=> (rdata_o[DATA_W-1:NUM_RATES] == '0));

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_w != '0) |=> ((flag_q & $past(set_w)) == $past(set_w)));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_w & ~set_w) != '0) |=> ((flag_q & $past(clr_w & ~set_w)) == '0));

  p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w == '0 && set_w == '0) |=> $stable(flag_q));

  p_irq_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_i) |=> irq_o);

  p_rdata_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_bcd_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w[3:0] <= 4'd9) && (cnt_w[7:4] <= 4'd9) && (cnt_w[11:8] <= 4'd9));
endmodule

bind stopwatch_tick_irq swt_tick_irq_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .NUM_RATES (NUM_RATES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .set_w   (set_w),
  .clr_w   (clr_w),
  .flag_q  (flag_q),
  .cnt_w   (digit_w)
);

// File: tb/tb_stopwatch_tick_irq.sv
module tb_stopwatch_tick_irq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  int cnt = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  stopwatch_tick_irq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (ticks=%0d)", req, act, exp, cnt);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); rd_i = 1'b1; addr_i = a;
    @(negedge clk_i); rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic tick();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    cnt++;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // read-twice rule: accept only two identical back-to-back reads
  task automatic rd_stable(input logic [1:0] a, output logic [7:0] d);
    logic [7:0] a0, a1;
    rd(a, a0); rd(a, a1);
    while (a0 != a1) begin a0 = a1; rd(a, a1); end
    d = a1;
  endtask

  task automatic check_cnt(input string tag);
    logic [7:0] lo, hi;
    rd_stable(2'd2, lo);
    rd_stable(2'd3, hi);
    check({tag, " R4 lo"}, lo, {4'((cnt / 10) % 10), 4'(cnt % 10)});
    check({tag, " R4 hi"}, hi, {4'h0, 4'((cnt / 100) % 10)});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [2:0] fexp;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1 irq", irq_o, 0);
    rd(2'd0, d); check("R1 en", d, 0);
    rd(2'd1, d); check("R1 flag", d, 0);
    check_cnt("R1");

    // R2 enable reg, reserved bits
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R2 en all", d, 8'h07);
    wr(2'd0, 8'h05); rd(2'd0, d); check("R2 en 101", d, 8'h05);
    wr(2'd0, 8'h00);

    // sweep 250 ticks; R5 R6 R7 R10 flags, R11 irq
    for (int t = 0; t < 250; t++) begin
      tick();
      fexp = {cnt % 100 == 50, cnt % 10 == 5, 1'b1};
      rd(2'd1, d);
      check("R3 rsvd", d[7:3], 0);
      check("R5 fast flag", d[0], fexp[0]);
      check("R6 mid flag", d[1], fexp[1]);
      check("R7 slow flag R10", d[2], fexp[2]);
      for (int e = 0; e < 8; e++) begin
        wr(2'd0, 8'(e));
        check("R11 irq", irq_o, int'(|(fexp & 3'(e))));
      end
      if (t % 25 == 0) check_cnt("sweep");
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h07);
    end
    rd(2'd1, d); check("R8 clear all", d, 0);

    // R12 counter ignores writes
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    check_cnt("R12");

    // R8 partial clears; reach a 4->5 step
    while (cnt % 10 != 4) tick();
    wr(2'd1, 8'h07);
    tick();
    rd(2'd1, d); check("R6 pre", d, 8'h03);
    wr(2'd1, 8'h00); rd(2'd1, d); check("R8 zero write", d, 8'h03);
    wr(2'd0, 8'h02); check("R11 hold", irq_o, 1);
    wr(2'd1, 8'h01); rd(2'd1, d); check("R8 clear bit0", d, 8'h02);
    check("R11 still", irq_o, 1);
    wr(2'd1, 8'h02); rd(2'd1, d); check("R8 clear bit1", d, 8'h00);
    check("R11 dropped", irq_o, 0);
    wr(2'd0, 8'h00);

    // R9 set and clear on the same edge
    while (cnt % 10 != 4) tick();
    wr(2'd1, 8'h07);
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0; wr_i = 1'b1; addr_i = 2'd1; wdata_i = 8'h02;
    @(negedge clk_i); wr_i = 1'b0;
    cnt++;
    repeat (2) @(negedge clk_i);
    rd(2'd1, d); check("R9 set wins", d[1], 1);

    // R13 data holds without a read strobe
    rd(2'd0, d);
    wr(2'd0, 8'h07);
    repeat (3) @(negedge clk_i);
    check("R13 hold", rdata_o, d);
    rd(2'd0, d); check("R13 fresh", d, 8'h07);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule